// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer whose write side and read side run on unrelated clocks. Each side has its own enable. Pointers cross between the two clock domains as Gray code through two-flop synchronisers. Besides the primary full and empty indications, the block drives three active-low level flags: almost-full, almost-empty and half-full. The almost-full threshold is set by an offset `m` on `af_off`. The almost-empty threshold is set by an offset `n` on `ae_off`. Both offsets are quasi-static inputs.

A parameter selects one of two output modes. In the registered-read mode the storage holds `DEPTH = 2**ADDR_W` words, and a word reaches `rd_data` one read-clock edge after an accepted read. In the fall-through mode the oldest word is shown on `rd_data` without a read request, and `rd_en` consumes it. The output register counts as storage, so the capacity becomes `DEPTH+1` and every level threshold moves up by one word. In this mode `wr_full` means "not ready for input" and `rd_empty` means "no word on the output".

The write side updates almost-full, half-full and `wr_full` from write-clock registers. The read side updates almost-empty and `rd_empty` from read-clock registers. A change made by the other side therefore reaches a flag only after synchronisation, and a release can come one own-clock cycle later when the two edges are close together.

Top module: `dcfifo_pf`

## Requirements
- R1: Capacity is CAP = DEPTH words in registered-read mode and DEPTH+1 words in fall-through mode. Once settled, `wr_full` is 1 exactly when CAP words are stored.
- R2: Words leave in the order they were accepted. In registered-read mode an accepted read puts the oldest word on `rd_data` one read-clock edge later. In fall-through mode the oldest stored word is on `rd_data` with no read request, and `rd_data` holds it until `rd_en` consumes it.
- R3: `almost_full_n` is 0 exactly when the stored count is at least CAP − m, with m taken from `af_off`. It is driven from write-clock state only.
- R4: `almost_empty_n` is 0 exactly when the stored count is at most n in registered-read mode, or at most n+1 in fall-through mode, with n taken from `ae_off`. It is driven from read-clock state only.
- R5: `half_full_n` is 0 exactly when the stored count is at least DEPTH/2+1 in registered-read mode, or at least DEPTH/2+2 in fall-through mode.
- R6: A write attempted while `wr_full` is 1 is dropped. No stored word is lost or replaced, and the stored count does not change.
- R7: A read attempted while `rd_empty` is 1 in registered-read mode leaves `rd_data` and the stored count unchanged.
- R8: After the synchronous active-high `rst`, the block is empty: `rd_empty`=1, `wr_full`=0, `almost_empty_n`=0, `almost_full_n`=1 (for m < CAP), `half_full_n`=1.
- R9: Once settled, `rd_empty` is 1 exactly when no word is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous reset, active high, held over edges of both clocks |
| wr_en | input | 1 | Write request, sampled on wr_clk |
| wr_data | input | DATA_W | Word to store |
| af_off | input | ADDR_W+2 | Almost-full offset m |
| ae_off | input | ADDR_W+2 | Almost-empty offset n |
| wr_full | output | 1 | Full (registered-read) / not input-ready (fall-through) |
| almost_full_n | output | 1 | Active-low almost-full flag |
| half_full_n | output | 1 | Active-low half-full flag |
| rd_en | input | 1 | Read request, sampled on rd_clk |
| rd_data | output | DATA_W | Output word |
| rd_empty | output | 1 | Empty (registered-read) / not output-ready (fall-through) |
| almost_empty_n | output | 1 | Active-low almost-empty flag |

## Verification
Both modes run in parallel on shared stimulus. Every pair of offsets m and n from 0 to 3 is tried with a fill of single writes from empty to two past capacity, then a drain of single reads to two past empty. Checking every flag at every level shows where each threshold sits and that the fall-through instance is shifted by exactly one word. The extra writes at full show that no word is lost or replaced. The extra reads at empty show that the output holds its value and that nothing is read twice. The data seen on the output, checked after every read, separates the registered-read timing from the fall-through head-of-queue presentation.

// File: rtl/fifo_pf_pkg.sv
package fifo_pf_pkg;

    localparam int GW = 16;

    typedef struct packed {
        logic full;
        logic af_n;
        logic hf_n;
    } wr_flags_t;

    typedef struct packed {
        logic empty;
        logic ae_n;
    } rd_flags_t;

    function automatic logic [GW-1:0] to_gray(input logic [GW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [GW-1:0] from_gray(input logic [GW-1:0] g);
        logic [GW-1:0] b;
        b[GW-1] = g[GW-1];
        for (int i = GW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    function automatic int capacity(input int addr_w, input bit ft);
        return (1 << addr_w) + (ft ? 1 : 0);
    endfunction

    function automatic int half_mark(input int addr_w, input bit ft);
        return (1 << addr_w) / 2 + 1 + (ft ? 1 : 0);
    endfunction

    function automatic logic upper_hit(input int level, input int off, input int cap);
        return (level + off) >= cap;
    endfunction

    function automatic logic lower_hit(input int level, input int off, input bit ft);
        return level <= (off + (ft ? 1 : 0));
    endfunction

endpackage

// File: rtl/fifo_pf_sync.sv
module fifo_pf_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/fifo_pf_wr.sv
module fifo_pf_wr
    import fifo_pf_pkg::*;
#(
    parameter int ADDR_W       = 3,
    parameter bit FALL_THROUGH = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W+1:0] af_off,
    input  logic [ADDR_W+1:0] fptr_g_s,
    input  logic [ADDR_W+1:0] cptr_g_s,
    output logic              push,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W+1:0] wptr,
    output logic [ADDR_W+1:0] wptr_g,
    output wr_flags_t         flags
);
    localparam int PW    = ADDR_W + 2;
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CAP   = capacity(ADDR_W, FALL_THROUGH);
    localparam int HALF  = half_mark(ADDR_W, FALL_THROUGH);

    logic [PW-1:0] fptr_s, cptr_s, wptr_nxt, ram_used, level;

    assign fptr_s   = PW'(from_gray(GW'(fptr_g_s)));
    assign cptr_s   = PW'(from_gray(GW'(cptr_g_s)));
    // RAM occupancy guards the storage; the consumed pointer gives the level.
    assign ram_used = wptr - fptr_s;
    assign level    = wptr - cptr_s;

    assign flags.full = (ram_used == PW'(DEPTH));
    assign flags.af_n = ~upper_hit(int'(level), int'(af_off), CAP);
    assign flags.hf_n = ~(int'(level) >= HALF);

    assign push     = wr_en & ~flags.full;
    assign waddr    = wptr[ADDR_W-1:0];
    assign wptr_nxt = wptr + PW'(push);

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr   <= '0;
            wptr_g <= '0;
        end else begin
            wptr   <= wptr_nxt;
            wptr_g <= PW'(to_gray(GW'(wptr_nxt)));
        end
    end
endmodule

// File: rtl/fifo_pf_rd.sv
module fifo_pf_rd
    import fifo_pf_pkg::*;
#(
    parameter int ADDR_W       = 3,
    parameter int DATA_W       = 8,
    parameter bit FALL_THROUGH = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W+1:0] ae_off,
    input  logic [ADDR_W+1:0] wptr_g_s,
    input  logic [DATA_W-1:0] mem_q,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W+1:0] fptr_g,
    output logic [ADDR_W+1:0] cptr_g,
    output logic [DATA_W-1:0] rd_data,
    output rd_flags_t         flags
);
    localparam int PW = ADDR_W + 2;

    logic [PW-1:0] wptr_s, fptr, fptr_nxt, cptr, cptr_nxt, level;
    logic          avail, fetch, empty;

    assign wptr_s   = PW'(from_gray(GW'(wptr_g_s)));
    assign avail    = (wptr_s != fptr);
    assign raddr    = fptr[ADDR_W-1:0];
    assign fptr_nxt = fptr + PW'(fetch);

    generate
        if (FALL_THROUGH) begin : g_ft
            logic out_valid;
            logic pop;
            // Prefetch into the output register whenever it is free or being drained.
            assign fetch    = avail & (~out_valid | rd_en);
            assign pop      = rd_en & out_valid;
            assign cptr_nxt = cptr + PW'(pop);
            assign empty    = ~out_valid;
            always_ff @(posedge clk) begin
                if (rst) begin
                    out_valid <= 1'b0;
                    cptr      <= '0;
                end else begin
                    out_valid <= fetch | (out_valid & ~pop);
                    cptr      <= cptr_nxt;
                end
            end
        end else begin : g_std
            assign fetch    = rd_en & avail;
            assign cptr     = fptr;
            assign cptr_nxt = fptr_nxt;
            assign empty    = ~avail;
        end
    endgenerate

    assign level       = wptr_s - cptr;
    assign flags.empty = empty;
    assign flags.ae_n  = ~lower_hit(int'(level), int'(ae_off), FALL_THROUGH);

    always_ff @(posedge clk) begin
        if (rst) begin
            fptr    <= '0;
            fptr_g  <= '0;
            cptr_g  <= '0;
            rd_data <= '0;
        end else begin
            fptr   <= fptr_nxt;
            fptr_g <= PW'(to_gray(GW'(fptr_nxt)));
            cptr_g <= PW'(to_gray(GW'(cptr_nxt)));
            if (fetch) begin
                rd_data <= mem_q;
            end
        end
    end
endmodule

// File: rtl/dcfifo_pf.sv
module dcfifo_pf
    import fifo_pf_pkg::*;
#(
    parameter int ADDR_W       = 3,
    parameter int DATA_W       = 8,
    parameter bit FALL_THROUGH = 1'b0
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W+1:0] af_off,
    input  logic [ADDR_W+1:0] ae_off,
    output logic              wr_full,
    output logic              almost_full_n,
    output logic              half_full_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty,
    output logic              almost_empty_n
);
    localparam int PW    = ADDR_W + 2;
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              push;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [PW-1:0]     wptr, wptr_g, wptr_g_s;
    logic [PW-1:0]     fptr_g, fptr_g_s, cptr_g, cptr_g_s;
    wr_flags_t         wflags;
    rd_flags_t         rflags;

    fifo_pf_wr #(.ADDR_W(ADDR_W), .FALL_THROUGH(FALL_THROUGH)) u_wr (
        .clk(wr_clk), .rst(rst), .wr_en(wr_en), .af_off(af_off),
        .fptr_g_s(fptr_g_s), .cptr_g_s(cptr_g_s),
        .push(push), .waddr(waddr), .wptr(wptr), .wptr_g(wptr_g), .flags(wflags)
    );

    fifo_pf_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FALL_THROUGH(FALL_THROUGH)) u_rd (
        .clk(rd_clk), .rst(rst), .rd_en(rd_en), .ae_off(ae_off),
        .wptr_g_s(wptr_g_s), .mem_q(mem[raddr]),
        .raddr(raddr), .fptr_g(fptr_g), .cptr_g(cptr_g),
        .rd_data(rd_data), .flags(rflags)
    );

    fifo_pf_sync #(.W(PW)) u_sync_w2r (.clk(rd_clk), .rst(rst), .d(wptr_g), .q(wptr_g_s));
    fifo_pf_sync #(.W(PW)) u_sync_f2w (.clk(wr_clk), .rst(rst), .d(fptr_g), .q(fptr_g_s));
    fifo_pf_sync #(.W(PW)) u_sync_c2w (.clk(wr_clk), .rst(rst), .d(cptr_g), .q(cptr_g_s));

    always_ff @(posedge wr_clk) begin
        if (push) begin
            mem[waddr] <= wr_data;
        end
    end

    assign wr_full        = wflags.full;
    assign almost_full_n  = wflags.af_n;
    assign half_full_n    = wflags.hf_n;
    assign rd_empty       = rflags.empty;
    assign almost_empty_n = rflags.ae_n;
endmodule

// File: rtl/fifo_pf_chk.sv
module fifo_pf_chk #(
    parameter int ADDR_W       = 3,
    parameter int DATA_W       = 8,
    parameter bit FALL_THROUGH = 1'b0
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic              wr_full,
    input logic              rd_empty,
    input logic              almost_full_n,
    input logic              almost_empty_n,
    input logic              half_full_n,
    input logic [ADDR_W+1:0] af_off,
    input logic [DATA_W-1:0] rd_data,
    input logic [ADDR_W+1:0] wptr
);
    localparam int CAP = (1 << ADDR_W) + (FALL_THROUGH ? 1 : 0);

    // R6
    no_overflow_chk: assert property (@(posedge wr_clk) disable iff (rst)
        (wr_full && wr_en) |=> $stable(wptr));

    // R5
    full_is_half_chk: assert property (@(posedge wr_clk) disable iff (rst)
        wr_full |-> !half_full_n);

    // R8
    wr_reset_state_chk: assert property (@(posedge wr_clk) disable iff (rst)
        ($past(rst) && int'(af_off) < CAP) |-> (!wr_full && almost_full_n && half_full_n));

    // R8
    rd_reset_state_chk: assert property (@(posedge rd_clk) disable iff (rst)
        $past(rst) |-> (rd_empty && !almost_empty_n));

    generate
        if (FALL_THROUGH) begin : g_ft
            // R2
            head_hold_chk: assert property (@(posedge rd_clk) disable iff (rst)
                (!rd_empty && !rd_en) |=> $stable(rd_data));
        end else begin : g_std
            // R7
            no_underflow_chk: assert property (@(posedge rd_clk) disable iff (rst)
                (rd_empty && rd_en) |=> $stable(rd_data));
            // R4
            empty_is_low_chk: assert property (@(posedge rd_clk) disable iff (rst)
                rd_empty |-> !almost_empty_n);
            // R3
            full_is_af_chk: assert property (@(posedge wr_clk) disable iff (rst)
                wr_full |-> !almost_full_n);
        end
    endgenerate
endmodule

bind dcfifo_pf fifo_pf_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FALL_THROUGH(FALL_THROUGH)
) u_chk (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .wr_full(wr_full), .rd_empty(rd_empty), .almost_full_n(almost_full_n),
    .almost_empty_n(almost_empty_n), .half_full_n(half_full_n),
    .af_off(af_off), .rd_data(rd_data), .wptr(wptr)
);

// File: tb/dcfifo_pf_bench.sv
module dcfifo_pf_bench;
    localparam int CLK_PERIOD = 10;
    localparam int RD_PERIOD  = 16;
    localparam int AW = 3;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    logic wr_clk = 1'b0, rd_clk = 1'b0, rst = 1'b1;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [AW+1:0] af_off = '0, ae_off = '0;

    logic s_full, s_afn, s_hfn, s_empty, s_aen;
    logic f_full, f_afn, f_hfn, f_empty, f_aen;
    logic [DW-1:0] s_q, f_q;

    int n_chk = 0, n_fail = 0;
    logic [DW-1:0] qs [16];
    logic [DW-1:0] qf [16];
    int hs = 0, ts = 0, hf = 0, tf = 0;
    logic [DW-1:0] last_s = '0;

    always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
    always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

    dcfifo_pf #(.ADDR_W(AW), .DATA_W(DW), .FALL_THROUGH(1'b0)) u_dcfifo_pf (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .af_off(af_off), .ae_off(ae_off), .wr_full(s_full), .almost_full_n(s_afn),
        .half_full_n(s_hfn), .rd_en(rd_en), .rd_data(s_q), .rd_empty(s_empty),
        .almost_empty_n(s_aen)
    );

    dcfifo_pf #(.ADDR_W(AW), .DATA_W(DW), .FALL_THROUGH(1'b1)) u_dcfifo_pf_ft (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .af_off(af_off), .ae_off(ae_off), .wr_full(f_full), .almost_full_n(f_afn),
        .half_full_n(f_hfn), .rd_en(rd_en), .rd_data(f_q), .rd_empty(f_empty),
        .almost_empty_n(f_aen)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic settle();
        repeat (5) @(negedge wr_clk);
        repeat (5) @(negedge rd_clk);
    endtask

    task automatic check_flags(input bit ft, input int cnt, input int m, input int n,
                               input logic full, input logic afn, input logic hfn,
                               input logic empty, input logic aen);
        int cap;
        cap = DEPTH + (ft ? 1 : 0);
        chk(ft ? "R1 ft" : "R1 std", "wr_full", int'(full), int'(cnt == cap));
        chk(ft ? "R9 ft" : "R9 std", "rd_empty", int'(empty), int'(cnt == 0));
        chk(ft ? "R3 ft" : "R3 std", "almost_full_n", int'(afn), int'(!(cnt >= cap - m)));
        chk(ft ? "R4 ft" : "R4 std", "almost_empty_n", int'(aen), int'(!(cnt <= n + (ft ? 1 : 0))));
        chk(ft ? "R5 ft" : "R5 std", "half_full_n", int'(hfn), int'(!(cnt >= DEPTH/2 + 1 + (ft ? 1 : 0))));
    endtask

    task automatic check_both(input int m, input int n);
        check_flags(1'b0, ts - hs, m, n, s_full, s_afn, s_hfn, s_empty, s_aen);
        check_flags(1'b1, tf - hf, m, n, f_full, f_afn, f_hfn, f_empty, f_aen);
        if (tf - hf > 0) chk("R2 ft", "head on rd_data", int'(f_q), int'(qf[hf % 16]));
    endtask

    task automatic write_one(input logic [DW-1:0] d);
        @(negedge wr_clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge wr_clk);
        wr_en = 1'b0;
        if (ts - hs < DEPTH) begin qs[ts % 16] = d; ts++; end      // R6 std drop at full
        if (tf - hf < DEPTH + 1) begin qf[tf % 16] = d; tf++; end  // R6 ft drop at full
        settle();
    endtask

    task automatic read_one();
        @(negedge rd_clk);
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
        if (ts - hs > 0) begin last_s = qs[hs % 16]; hs++; end
        if (tf - hf > 0) hf++;
        settle();
        // R2 popped word in std mode, R7 held value when read while empty
        chk("R2/R7 std", "rd_data", int'(s_q), int'(last_s));
    endtask

    initial begin
        #201;
        rst = 1'b0;
        settle();
        chk("R8", "std rd_empty", int'(s_empty), 1);
        chk("R8", "std wr_full", int'(s_full), 0);
        chk("R8", "std almost_empty_n", int'(s_aen), 0);
        chk("R8", "std almost_full_n", int'(s_afn), 1);
        chk("R8", "std half_full_n", int'(s_hfn), 1);
        chk("R8", "ft rd_empty", int'(f_empty), 1);
        chk("R8", "ft wr_full", int'(f_full), 0);
        chk("R8", "ft almost_empty_n", int'(f_aen), 0);
        chk("R8", "ft almost_full_n", int'(f_afn), 1);
        chk("R8", "ft half_full_n", int'(f_hfn), 1);
        for (int m = 0; m < 4; m++) begin
            for (int n = 0; n < 4; n++) begin
                af_off = (AW+2)'(m);
                ae_off = (AW+2)'(n);
                settle();
                check_both(m, n);
                for (int i = 0; i < DEPTH + 3; i++) begin
                    write_one(DW'(m * 64 + n * 16 + i + 1));
                    check_both(m, n);
                end
                for (int i = 0; i < DEPTH + 3; i++) begin
                    read_one();
                    check_both(m, n);
                end
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule